// File: doc/BRIEF.md
# Dual-Mode Peripheral Port

This block drives eleven board pins that serve either as general-purpose IO or as a small multiplexed-bus master for byte-wide peripherals such as codecs and tone decoders. A host writes a control register to pick the mode and the pin directions. It then works through an address register and a data register. In general-purpose mode those two registers hold the output levels and return the live pin levels. In bus mode, writing the address register and then writing or reading the data register runs one complete peripheral cycle on the pins.

The bus cycle multiplexes address and data on eight lines and uses one latch pin and two active-low strobes. A busy flag covers the whole cycle. Host accesses made while the flag is set are dropped. On every mode switch all pins float for a short settle window.

Top module: `periph_port`

## Requirements
- R1: After reset the block is in general-purpose mode with every direction bit clear, so `pin_oe` is 0, `busy` is 0 and the control register reads 0.
- R2: Control register (select 0): bit 7 is the mode (0 general-purpose, 1 bus), bit 6 reads 0, and bits 5:0 are direction enables. Bits 0..3 each drive a pin pair (2k+1:2k), bit 4 drives pin 8 and bit 5 drives pins 9 and 10. A read returns the last written value with bit 6 clear.
- R3: In general-purpose mode, the address register (select 1) sets the output levels of pins 7:0 and data register bits 2:0 (select 2) set pins 10:8. The new levels appear on `pin_out` of enabled pins in the cycle after the write edge.
- R4: In general-purpose mode, reading the address register returns, for each of pins 7:0, the register bit where that pin is an output and `pin_in` where it is an input. Reading the data register returns the same for pins 10:8 in bits 2:0, with bits 7:3 zero.
- R5: A control write that changes the mode forces `pin_oe` to 0 for SETTLE_CYC (default 2) cycles after the write edge. No bus cycle can start during that window.
- R6: In bus mode a data-register write runs this sequence, counted in cycles after the write edge. Cycles 1-2: address on pins 7:0 with latch pin 8 high. Cycle 3: latch low, address held. Cycles 4-8: write data driven. Cycles 5-8: write strobe pin 10 low. Cycle 9: strobe high and pins 7:0 released.
- R7: In bus mode a data-register read (a `host_rd` pulse with select 2) runs the same phases with pins 7:0 released from cycle 4 and read strobe pin 9 low in cycles 5-8. `pin_in[7:0]` is captured on the edge where the strobe returns high, and the data register then reads back that byte.
- R8: `busy` is 1 in cycles 1-9 of a bus cycle. While it is set, every host write and every data read is ignored.
- R9: In bus mode with no cycle running, pins 8-10 are driven with latch low and both strobes high, and pins 7:0 are released.
- R10: In general-purpose mode, accesses to the data register never start a bus cycle, so `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (launches bus reads) |
| host_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | Bus cycle in progress |
| pin_in | input | 11 | Sampled pin levels |
| pin_out | output | 11 | Pin output levels |
| pin_oe | output | 11 | Pin output enables |

## Verification
General-purpose output levels and direction changes are due on the first cycle after the write edge. Bus-cycle pin states are due on cycles 1 to 9 after the launching edge, with `busy` clearing on cycle 10. Floating after a mode switch covers cycles 1 and 2. Every time a stimulus lands, the driver queues one expected pin state per cycle. The monitor pops one entry at each falling edge plus 1 ns, so each entry is compared in exactly the cycle it names. Read-back values are sampled only after the queue has drained, so the capture edge has already passed.

// File: rtl/periph_port_pkg.sv
package periph_port_pkg;
   localparam int PIN_N  = 11;
   localparam int AD_W   = 8;
   localparam int DIR_W  = 6;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_ADDR = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LATCH,
      PH_HOLD,
      PH_TURN,
      PH_STROBE,
      PH_END
   } phase_e;
endpackage

// File: rtl/periph_port_regs.sv
module periph_port_regs
   import periph_port_pkg::*;
#(
   parameter int SETTLE_CYC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  reg_sel_e         sel,
   input  logic [AD_W-1:0]  wdata,
   input  logic             busy,
   output logic             mode,
   output logic [DIR_W-1:0] dir_bits,
   output logic [AD_W-1:0]  addr_q,
   output logic [AD_W-1:0]  data_q,
   output logic             settle,
   output logic             start_wr,
   output logic             start_rd
);
   localparam int SET_W = $clog2(SETTLE_CYC + 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [SET_W-1:0] settle_cnt;
   logic             wr_ok;
   logic             unused_ctrl_bit;

   assign unused_ctrl_bit = wdata[6];
   assign wr_ok    = host_wr & ~busy;
   assign settle   = (settle_cnt != '0);
   assign start_wr = wr_ok & mode & ~settle & (sel == REG_DATA);
   assign start_rd = host_rd & ~busy & mode & ~settle & (sel == REG_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode       <= 1'b0;
         dir_bits   <= '0;
         addr_q     <= '0;
         data_q     <= '0;
         settle_cnt <= '0;
      end else begin
         if (settle_cnt != '0) settle_cnt <= settle_cnt - 1'b1;
         if (wr_ok) begin
            case (sel)
               REG_CTRL: begin
                  dir_bits <= wdata[DIR_W-1:0];
                  mode     <= wdata[7];
                  if (wdata[7] != mode) settle_cnt <= SET_W'(SETTLE_CYC);
               end
               REG_ADDR: addr_q <= wdata;
               REG_DATA: data_q <= wdata;
               default: ;
            endcase
         end
      end
   end

   AST_BUSY_WRITES_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr) |=> ($stable(addr_q) && $stable(data_q) && $stable(mode))); // R8
   AST_SWITCH_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !busy && sel == REG_CTRL && wdata[7] != mode) |=> settle); // R5
endmodule

// File: rtl/periph_port_seq.sv
module periph_port_seq
   import periph_port_pkg::*;
#(
   parameter int LATCH_CYC  = 2,
   parameter int STROBE_CYC = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_wr,
   input  logic            start_rd,
   input  logic [AD_W-1:0] pin_ad,
   output phase_e          phase,
   output logic            is_read,
   output logic            busy,
   output logic [AD_W-1:0] rdata_q
);
   localparam int MAX_CYC = (LATCH_CYC > STROBE_CYC) ? LATCH_CYC : STROBE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   generate
      if (LATCH_CYC < 1 || STROBE_CYC < 1) begin : g_bad_len
         $error("phase lengths must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   assign busy = (phase != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         is_read <= 1'b0;
         rdata_q <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (start_wr || start_rd) begin
               phase   <= PH_LATCH;
               cnt     <= CNT_W'(LATCH_CYC - 1);
               is_read <= start_rd & ~start_wr;
            end
            PH_LATCH: begin
               if (cnt == '0) phase <= PH_HOLD;
               else cnt <= cnt - 1'b1;
            end
            PH_HOLD: phase <= PH_TURN;
            PH_TURN: begin
               phase <= PH_STROBE;
               cnt   <= CNT_W'(STROBE_CYC - 1);
            end
            PH_STROBE: begin
               if (cnt == '0) begin
                  phase <= PH_END;
                  if (is_read) rdata_q <= pin_ad;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ((start_wr || start_rd) && !busy) |=> busy); // R8
endmodule

// File: rtl/periph_port_pinmux.sv
module periph_port_pinmux
   import periph_port_pkg::*;
#(
   parameter int STROBE_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode,
   input  logic             settle,
   input  logic [DIR_W-1:0] dir_bits,
   input  logic [AD_W-1:0]  addr_q,
   input  logic [AD_W-1:0]  data_q,
   input  phase_e           phase,
   input  logic             is_read,
   output logic [PIN_N-1:0] cfg_oe,
   output logic [PIN_N-1:0] pin_out,
   output logic [PIN_N-1:0] pin_oe
);
   localparam int PAIRS = AD_W / 2;
   localparam int RUN_W = $clog2(STROBE_CYC + 2);

   genvar g;
   generate
      for (g = 0; g < PAIRS; g++) begin : g_pair
         assign cfg_oe[2*g+1:2*g] = {2{dir_bits[g]}};
      end
   endgenerate
   assign cfg_oe[AD_W]              = dir_bits[PAIRS];
   assign cfg_oe[PIN_N-1:AD_W+1]    = {2{dir_bits[PAIRS+1]}};

   logic [PIN_N-1:0] gpio_out, bus_out, bus_oe;
   logic             ale, rd_n, wr_n, ad_drv, show_addr;

   assign gpio_out  = {data_q[2:0], addr_q};
   assign show_addr = (phase == PH_LATCH) || (phase == PH_HOLD);
   assign ale       = (phase == PH_LATCH);
   assign rd_n      = ~((phase == PH_STROBE) && is_read);
   assign wr_n      = ~((phase == PH_STROBE) && !is_read);
   assign ad_drv    = show_addr ||
                      (!is_read && (phase == PH_TURN || phase == PH_STROBE));
   assign bus_out   = {wr_n, rd_n, ale, show_addr ? addr_q : data_q};
   assign bus_oe    = {3'b111, {AD_W{ad_drv}}};

   always_comb begin
      if (settle)    pin_oe = '0;
      else if (mode) pin_oe = bus_oe;
      else           pin_oe = cfg_oe;
      pin_out = mode ? bus_out : gpio_out;
   end

   logic             strobe_low;
   logic [RUN_W-1:0] low_run;
   assign strobe_low = mode && ((pin_oe[9] && !pin_out[9]) || (pin_oe[10] && !pin_out[10]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_run <= '0;
      else if (strobe_low) low_run <= low_run + 1'b1;
      else                 low_run <= '0;
   end

   AST_FLOAT_WHILE_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      settle |-> (pin_oe == '0)); // R5
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mode |-> !(pin_oe[9] && pin_oe[10] && !pin_out[9] && !pin_out[10])); // R6
   AST_LATCH_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && pin_oe[8] && pin_out[8]) |-> (pin_oe[7:0] == 8'hFF)); // R6
   AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode && pin_oe[9] && !pin_out[9]) |-> (pin_oe[7:0] == 8'h00)); // R7
   AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      (low_run != '0 && !strobe_low) |-> (low_run == RUN_W'(STROBE_CYC))); // R6
endmodule

// File: rtl/periph_port.sv
module periph_port
   import periph_port_pkg::*;
#(
   parameter int SETTLE_CYC = 2,
   parameter int LATCH_CYC  = 2,
   parameter int STROBE_CYC = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [1:0]  host_sel,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata,
   output logic        busy,
   input  logic [10:0] pin_in,
   output logic [10:0] pin_out,
   output logic [10:0] pin_oe
);
   reg_sel_e         sel;
   logic             mode, settle, start_wr, start_rd, is_read;
   logic [DIR_W-1:0] dir_bits;
   logic [AD_W-1:0]  addr_q, data_q, rdata_q;
   logic [PIN_N-1:0] cfg_oe, level;
   phase_e           phase;

   assign sel = reg_sel_e'(host_sel);

   periph_port_regs #(.SETTLE_CYC(SETTLE_CYC)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .sel(sel), .wdata(host_wdata), .busy(busy), .mode(mode),
      .dir_bits(dir_bits), .addr_q(addr_q), .data_q(data_q),
      .settle(settle), .start_wr(start_wr), .start_rd(start_rd)
   );

   periph_port_seq #(.LATCH_CYC(LATCH_CYC), .STROBE_CYC(STROBE_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
      .pin_ad(pin_in[AD_W-1:0]), .phase(phase), .is_read(is_read),
      .busy(busy), .rdata_q(rdata_q)
   );

   periph_port_pinmux #(.STROBE_CYC(STROBE_CYC)) u_pinmux (
      .clk(clk), .rst_n(rst_n), .mode(mode), .settle(settle),
      .dir_bits(dir_bits), .addr_q(addr_q), .data_q(data_q),
      .phase(phase), .is_read(is_read), .cfg_oe(cfg_oe),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   assign level = (cfg_oe & {data_q[2:0], addr_q}) | (~cfg_oe & pin_in);

   always_comb begin
      case (sel)
         REG_CTRL: host_rdata = {mode, 1'b0, dir_bits};
         REG_ADDR: host_rdata = mode ? addr_q : level[AD_W-1:0];
         REG_DATA: host_rdata = mode ? rdata_q : {5'b0, level[PIN_N-1:AD_W]};
         default:  host_rdata = '0;
      endcase
   end

   AST_GPIO_NEVER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode && !busy) |=> !busy); // R10
endmodule

// File: tb/periph_port_bench.sv
`timescale 1ns/1ps
module periph_port_bench;
   localparam logic [1:0] S_CTRL = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_sel = S_CTRL;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        busy;
   logic [10:0] pin_in = '0;
   logic [10:0] pin_out, pin_oe;

   int checks = 0, failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   periph_port u_periph_port (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   typedef struct {
      string       tag;
      logic [10:0] oe;
      logic [10:0] out;
      logic        bsy;
   } exp_t;
   exp_t sbq[$];

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   function automatic void push(string tag, logic [10:0] oe, logic [10:0] out, logic b);
      exp_t e;
      e.tag = tag; e.oe = oe; e.out = out; e.bsy = b;
      sbq.push_back(e);
   endfunction

   function automatic logic [10:0] expand(logic [5:0] d);
      return {{2{d[5]}}, d[4], {2{d[3]}}, {2{d[2]}}, {2{d[1]}}, {2{d[0]}}};
   endfunction

   // Monitor: one queued expectation per cycle, sampled 1 ns after the falling edge.
   always @(negedge clk) begin
      #1;
      if (sbq.size() > 0) begin
         exp_t e;
         e = sbq.pop_front();
         check(e.tag, {busy, pin_oe, pin_out & pin_oe}, {e.bsy, e.oe, e.out & e.oe});
      end
   end

   task automatic reg_wr(logic [1:0] s, logic [7:0] d);
      @(negedge clk); host_wr = 1'b1; host_sel = s; host_wdata = d;
      @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic rd_pulse(logic [1:0] s);
      @(negedge clk); host_rd = 1'b1; host_sel = s;
      @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic reg_rd(logic [1:0] s, output logic [7:0] v);
      @(negedge clk); host_sel = s; #1 v = host_rdata;
   endtask

   task automatic drain();
      while (sbq.size() > 0) @(negedge clk);
      #2;
   endtask

   // Expected pin trace of a bus cycle, cycles 1..11 after the launching edge.
   function automatic void push_bus(string tag, bit rd, logic [7:0] a, logic [7:0] d);
      push(tag, 11'h7FF, {3'b111, a}, 1);                    // cycles 1-2: latch
      push(tag, 11'h7FF, {3'b111, a}, 1);
      push(tag, 11'h7FF, {3'b110, a}, 1);                    // cycle 3: hold
      push(tag, rd ? 11'h700 : 11'h7FF, {3'b110, d}, 1);     // cycle 4: turnaround
      for (int k = 0; k < 4; k++)                            // cycles 5-8: strobe
         push(tag, rd ? 11'h700 : 11'h7FF, rd ? {3'b100, d} : {3'b010, d}, 1);
      push(tag, 11'h700, 11'h600, 1);                        // cycle 9: end
      push("R9", 11'h700, 11'h600, 0);
      push("R9", 11'h700, 11'h600, 0);
   endfunction

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [10:0] oe;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 oe", pin_oe, 0);
      check("R1 busy", busy, 0);
      reg_rd(S_CTRL, v); check("R1 ctrl", v, 0);

      // R3 / R10: general-purpose outputs, pattern 1
      reg_wr(S_CTRL, 8'h15);
      reg_wr(S_ADDR, 8'hA5);
      reg_wr(S_DATA, 8'h05);
      push("R3", expand(6'h15), {3'b101, 8'hA5}, 0);          // R10: busy stays 0
      drain();
      // R2: pattern 2, other direction groups
      reg_wr(S_CTRL, 8'h2A);
      push("R2", expand(6'h2A), {3'b101, 8'hA5}, 0);
      drain();
      reg_rd(S_CTRL, v); check("R2 ctrl", v, 8'h2A);
      // R4: read-back mixes register and live levels
      pin_in = 11'h6CA;
      oe = expand(6'h2A);
      reg_rd(S_ADDR, v);
      check("R4 addr", v, (oe[7:0] & 8'hA5) | (~oe[7:0] & 8'hCA));
      reg_rd(S_DATA, v);
      check("R4 data", v, {5'b0, (oe[10:8] & 3'b101) | (~oe[10:8] & 3'b110)});
      // R10: data read in general-purpose mode starts nothing
      rd_pulse(S_DATA);
      push("R10", oe, {3'b101, 8'hA5}, 0);
      push("R10", oe, {3'b101, 8'hA5}, 0);
      drain();

      // R5: switch to bus mode, pins float two cycles
      reg_wr(S_CTRL, 8'hAA);
      push("R5", 11'h000, 11'h000, 0);
      push("R5", 11'h000, 11'h000, 0);
      push("R9", 11'h700, 11'h600, 0);
      drain();
      reg_rd(S_CTRL, v); check("R2 ctrl bus", v, 8'hAA);

      // R6 + R8: write cycle with dropped accesses during busy
      reg_wr(S_ADDR, 8'h3C);
      push("R9", 11'h700, 11'h600, 0);
      drain();
      reg_wr(S_DATA, 8'h5A);
      push_bus("R6", 0, 8'h3C, 8'h5A);
      reg_wr(S_DATA, 8'hFF);        // R8: ignored
      reg_wr(S_ADDR, 8'h11);        // R8: ignored
      rd_pulse(S_DATA);             // R8: ignored
      drain();
      reg_rd(S_ADDR, v); check("R8 addr kept", v, 8'h3C);

      // R7: read cycles, capture on strobe rising edge
      pin_in = 11'h0C3;
      rd_pulse(S_DATA);
      push_bus("R7", 1, 8'h3C, 8'h00);
      repeat (8) @(negedge clk);
      pin_in = 11'h00F;
      drain();
      reg_rd(S_DATA, v); check("R7 capture", v, 8'hC3);

      reg_wr(S_ADDR, 8'hF0);
      pin_in = 11'h099;
      rd_pulse(S_DATA);
      push_bus("R7", 1, 8'hF0, 8'h00);
      repeat (8) @(negedge clk);
      pin_in = 11'h066;
      drain();
      reg_rd(S_DATA, v); check("R7 capture 2", v, 8'h99);

      // R5: back to general-purpose mode
      reg_wr(S_CTRL, 8'h15);
      push("R5", 11'h000, 11'h000, 0);
      push("R5", 11'h000, 11'h000, 0);
      push("R5", expand(6'h15), {3'b010, 8'hF0}, 0);
      drain();

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule